// File: doc/BRIEF.md
# I2C Master Chunked Transfer Sequencer

This block is the byte-level engine of a register-driven I2C controller. Software writes a 32-bit control word carrying a 7-bit target address, a direction bit, an 8-bit byte count and a reload flag, together with a start request. The engine then opens the bus and clocks out the address byte. It moves data bytes through a transmit holding register or a receive holding register, paced by per-byte ready flags. At the end of a message it parks the bus in one of two states and waits for software. In the first, the count has run out and a reload is wanted. In the second, the message is finished and software must choose between a STOP and a repeated START.

Bit-level SCL/SDA timing is not done here. Each START, STOP, single-bit write or single-bit read is handed to a separate timing generator over a one-command-at-a-time strobe handshake. The engine waits for that generator's done pulse, which also returns the sampled SDA value. Whenever the engine has nothing issued, the bus is held, so the timing generator keeps SCL low. A NACK from the target ends the message early with an automatic STOP.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, and in the cycle after any cycle in which `enable_i` is low, `status_o` is zero, `irq_o` is low and `cmd_valid_o` is low.
- R2: A control write with bit 13 set while idle issues a START. It then issues eight write bits carrying {address (control bits 7:1), read flag (control bit 10)}, most significant first, and one read bit for the acknowledge. Busy (status bit 15) stays set from the START until the STOP completes.
- R3: In a write message, TXIS (status bit 1) rises whenever a byte is needed. A `tx_wr_i` pulse clears it, and that byte goes out as eight write bits, most significant first, followed by one acknowledge read.
- R4: In a read message, each byte is eight read bits, most significant first. The byte appears on `rx_data_o` with RXNE (status bit 2) set, and a `rx_rd_i` pulse clears RXNE. The engine answers each byte with a write bit of 0, except the last byte of a chunk without reload, which gets a 1.
- R5: If RXNE is still set when the next byte has been shifted in, the engine issues nothing more until RXNE is cleared. Both RXNE and `rx_data_o` stay unchanged meanwhile.
- R6: When the count (control bits 23:16) runs out with reload clear, TC (status bit 6) is set and nothing is issued until a control write. A write with bit 14 set then issues STOP. Bit 13 alone issues a repeated START with the new address, direction and count. If both bits are set, STOP wins.
- R7: When the count runs out with reload (control bit 24) set, TCR (status bit 7) is set instead of TC. The next control write loads a new count and reload flag, and transfer continues in the same direction without a START. TC and TCR are never set together.
- R8: A count of zero goes straight from the address acknowledge to TC or TCR.
- R9: An acknowledge bit read as 1, after the address or after a data byte, sets NACKF (status bit 4). The engine then issues STOP at once and drops the remaining count.
- R10: Completion of a STOP sets STOPF (status bit 5) and clears busy. Writing the clear word with bit 4 or bit 5 set clears NACKF or STOPF. Zero bits in the clear word leave the flags as they are.
- R11: `cmd_o` codes are 0 START, 1 STOP, 2 write bit (value on `cmd_bit_o`), 3 read bit. While `cmd_valid_o` is high and `bit_done_i` is low, the valid, the code and the bit stay unchanged in the next cycle.
- R12: `irq_o` is the OR of the flags gated by `ie_i`, with bit 0 for TXIS, bit 1 for RXNE, bit 2 for NACKF, bit 3 for STOPF and bit 4 for TC or TCR.
- R13: Dropping `enable_i` in the middle of a message abandons it. Status clears and no command is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Peripheral enable; low holds the block cleared |
| ie_i | input | 5 | Interrupt enables {tc/tcr, stopf, nackf, rxne, txis} |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_i | input | 32 | Control word |
| tx_wr_i | input | 1 | Transmit holding register write strobe |
| tx_data_i | input | 8 | Transmit byte |
| rx_rd_i | input | 1 | Receive holding register read strobe |
| rx_data_o | output | 8 | Receive byte |
| clr_wr_i | input | 1 | Flag clear write strobe |
| clr_i | input | 32 | Flag clear word (bit 4 NACKF, bit 5 STOPF) |
| status_o | output | 16 | Status flags |
| irq_o | output | 1 | Interrupt request |
| cmd_valid_o | output | 1 | Bus command pending to timing generator |
| cmd_o | output | 2 | Bus command code |
| cmd_bit_o | output | 1 | Bit value for a write-bit command |
| bit_done_i | input | 1 | Timing generator finished the pending command |
| bit_rx_i | input | 1 | SDA value sampled by a read-bit command |

## Verification
The bench aims at the seams between chunks and messages. These are a zero count, a reload chunk in both directions, a repeated START, and a control word asking for START and STOP together. A design that mishandled any of them would issue a stray START, lose a byte, or acknowledge the wrong byte with NACK, and the logged command stream would differ from the expected one. A slow reader that leaves RXNE set must stall the bus with no overrun. NACK on the address and on a middle data byte must give an immediate STOP rather than more data. Disabling mid-message must leave no command pending.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int CNT_W = 8;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  // control word fields
  localparam int C_ADDR_LSB = 1;
  localparam int C_RD       = 10;
  localparam int C_START    = 13;
  localparam int C_STOP     = 14;
  localparam int C_CNT_LSB  = 16;
  localparam int C_RELOAD   = C_CNT_LSB + CNT_W;

  // internal flag indices
  localparam int FL_TXIS = 0;
  localparam int FL_RXNE = 1;
  localparam int FL_NACK = 2;
  localparam int FL_STOP = 3;
  localparam int FL_TC   = 4;
  localparam int FL_TCR  = 5;
  localparam int FL_BUSY = 6;
  localparam int NFLAG   = 7;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } bitcmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_AACK, ST_TXWAIT, ST_TXBIT, ST_TXACK,
    ST_RXBIT, ST_RXHOLD, ST_RXACK, ST_TC, ST_TCR, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2cseq_bitif.sv
module i2cseq_bitif
  import i2cseq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    go_i,
  input  bitcmd_e cmd_i,
  input  logic    bit_i,
  output logic    idle_o,
  output logic    done_o,
  output logic    rx_o,
  output logic    cmd_valid_o,
  output bitcmd_e cmd_o,
  output logic    cmd_bit_o,
  input  logic    bit_done_i,
  input  logic    bit_rx_i
);
  logic    pend_q;
  bitcmd_e cmd_q;
  logic    bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cmd_q  <= CMD_START;
      bit_q  <= 1'b1;
    end else if (!en_i) begin
      pend_q <= 1'b0;
    end else if (!pend_q && go_i) begin
      pend_q <= 1'b1;
      cmd_q  <= cmd_i;
      bit_q  <= bit_i;
    end else if (pend_q && bit_done_i) begin
      pend_q <= 1'b0;
    end
  end

  assign idle_o      = !pend_q;
  assign done_o      = pend_q & bit_done_i;
  assign rx_o        = bit_rx_i;
  assign cmd_valid_o = pend_q;
  assign cmd_o       = cmd_q;
  assign cmd_bit_o   = bit_q;
endmodule

// File: rtl/i2cseq_flags.sv
module i2cseq_flags #(
  parameter int NF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] q_o
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      f_q <= 1'b0;
      else if (!en_i)   f_q <= 1'b0;
      else if (set_i[i]) f_q <= 1'b1;   // set wins over clear
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign q_o[i] = f_q;
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cseq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic [4:0]  ie_i,
  input  logic        ctrl_wr_i,
  input  logic [31:0] ctrl_i,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_data_i,
  input  logic        rx_rd_i,
  output logic [7:0]  rx_data_o,
  input  logic        clr_wr_i,
  input  logic [31:0] clr_i,
  output logic [15:0] status_o,
  output logic        irq_o,
  output logic        cmd_valid_o,
  output logic [1:0]  cmd_o,
  output logic        cmd_bit_o,
  input  logic        bit_done_i,
  input  logic        bit_rx_i
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] BC_TOP = BC_W'(BYTE_W - 1);

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d, rl_q, rl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, rem;
  logic [BYTE_W-1:0] sh_q, sh_d, rxd_q, rxd_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [NFLAG-1:0]  fl, fset, fclr;
  logic              adv, go, gbit, b_idle, b_done, b_rx;
  bitcmd_e           gcmd, b_cmd;

  // control word decode
  logic [ADDR_W-1:0] w_addr;
  logic [CNT_W-1:0]  w_cnt;
  logic              w_rd, w_start, w_stop, w_rl;
  assign w_addr  = ctrl_i[C_ADDR_LSB +: ADDR_W];
  assign w_cnt   = ctrl_i[C_CNT_LSB +: CNT_W];
  assign w_rd    = ctrl_i[C_RD];
  assign w_start = ctrl_i[C_START];
  assign w_stop  = ctrl_i[C_STOP];
  assign w_rl    = ctrl_i[C_RELOAD];

  logic unused_bits;
  assign unused_bits = ^{ctrl_i[31:C_RELOAD+1], ctrl_i[15], ctrl_i[12:11], ctrl_i[9:8],
                         ctrl_i[0], clr_i[31:6], clr_i[3:0]};

  always_comb begin
    st_d = st_q; addr_d = addr_q; rd_d = rd_q; rl_d = rl_q; cnt_d = cnt_q;
    sh_d = sh_q; bc_d = bc_q; rxd_d = rxd_q;
    fset = '0; fclr = '0;
    go = 1'b0; gcmd = CMD_START; gbit = 1'b1;
    adv = 1'b0; rem = cnt_q;
    fclr[FL_RXNE] = rx_rd_i;
    if (clr_wr_i) begin
      fclr[FL_NACK] = clr_i[4];
      fclr[FL_STOP] = clr_i[5];
    end
    unique case (st_q)
      ST_IDLE: if (ctrl_wr_i && w_start) begin
        addr_d = w_addr; rd_d = w_rd; cnt_d = w_cnt; rl_d = w_rl;
        fset[FL_BUSY] = 1'b1;
        st_d = ST_START;
      end
      ST_START: begin
        go = b_idle; gcmd = CMD_START;
        if (b_done) begin
          sh_d = {addr_q, rd_q}; bc_d = BC_TOP; st_d = ST_ADDR;
        end
      end
      ST_ADDR, ST_TXBIT: begin
        go = b_idle; gcmd = CMD_WRITE; gbit = sh_q[BYTE_W-1];
        if (b_done) begin
          sh_d = {sh_q[BYTE_W-2:0], 1'b0};
          bc_d = bc_q - 1'b1;
          if (bc_q == '0) st_d = (st_q == ST_ADDR) ? ST_AACK : ST_TXACK;
        end
      end
      ST_AACK, ST_TXACK: begin
        go = b_idle; gcmd = CMD_READ;
        if (b_done) begin
          if (b_rx) begin
            fset[FL_NACK] = 1'b1; st_d = ST_STOP;
          end else begin
            adv = 1'b1;
            rem = (st_q == ST_TXACK) ? cnt_q - 1'b1 : cnt_q;
          end
        end
      end
      ST_TXWAIT: if (tx_wr_i) begin
        sh_d = tx_data_i; bc_d = BC_TOP; fclr[FL_TXIS] = 1'b1; st_d = ST_TXBIT;
      end
      ST_RXBIT: begin
        go = b_idle; gcmd = CMD_READ;
        if (b_done) begin
          sh_d = {sh_q[BYTE_W-2:0], b_rx};
          bc_d = bc_q - 1'b1;
          if (bc_q == '0) st_d = ST_RXHOLD;
        end
      end
      ST_RXHOLD: if (!fl[FL_RXNE]) begin
        rxd_d = sh_q; fset[FL_RXNE] = 1'b1; st_d = ST_RXACK;
      end
      ST_RXACK: begin
        go = b_idle; gcmd = CMD_WRITE;
        gbit = (cnt_q == CNT_W'(1)) && !rl_q;   // NACK closes a final chunk
        if (b_done) begin
          adv = 1'b1; rem = cnt_q - 1'b1;
        end
      end
      ST_TCR: if (ctrl_wr_i) begin
        fclr[FL_TCR] = 1'b1; rl_d = w_rl; adv = 1'b1; rem = w_cnt;
      end
      ST_TC: if (ctrl_wr_i) begin
        if (w_stop) begin
          fclr[FL_TC] = 1'b1; st_d = ST_STOP;
        end else if (w_start) begin
          fclr[FL_TC] = 1'b1;
          addr_d = w_addr; rd_d = w_rd; cnt_d = w_cnt; rl_d = w_rl;
          st_d = ST_START;
        end
      end
      ST_STOP: begin
        go = b_idle; gcmd = CMD_STOP;
        if (b_done) begin
          fset[FL_STOP] = 1'b1; fclr[FL_BUSY] = 1'b1; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    // chunk bookkeeping after an acknowledged byte or a reload
    if (adv) begin
      cnt_d = rem;
      if (rem == '0) begin
        if (rl_d) begin fset[FL_TCR] = 1'b1; st_d = ST_TCR; end
        else      begin fset[FL_TC]  = 1'b1; st_d = ST_TC;  end
      end else if (rd_q) begin
        bc_d = BC_TOP; st_d = ST_RXBIT;
      end else begin
        fset[FL_TXIS] = 1'b1; st_d = ST_TXWAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; addr_q <= '0; rd_q <= 1'b0; rl_q <= 1'b0; cnt_q <= '0;
      sh_q <= '0; bc_q <= '0; rxd_q <= '0;
    end else if (!enable_i) begin
      st_q <= ST_IDLE; addr_q <= '0; rd_q <= 1'b0; rl_q <= 1'b0; cnt_q <= '0;
      sh_q <= '0; bc_q <= '0; rxd_q <= '0;
    end else begin
      st_q <= st_d; addr_q <= addr_d; rd_q <= rd_d; rl_q <= rl_d; cnt_q <= cnt_d;
      sh_q <= sh_d; bc_q <= bc_d; rxd_q <= rxd_d;
    end
  end

  i2cseq_bitif u_bitif (
    .clk_i, .rst_ni, .en_i(enable_i), .go_i(go), .cmd_i(gcmd), .bit_i(gbit),
    .idle_o(b_idle), .done_o(b_done), .rx_o(b_rx),
    .cmd_valid_o, .cmd_o(b_cmd), .cmd_bit_o,
    .bit_done_i, .bit_rx_i
  );
  assign cmd_o = b_cmd;

  i2cseq_flags #(.NF(NFLAG)) u_flags (
    .clk_i, .rst_ni, .en_i(enable_i), .set_i(fset), .clr_i(fclr), .q_o(fl)
  );

  always_comb begin
    status_o     = '0;
    status_o[1]  = fl[FL_TXIS];
    status_o[2]  = fl[FL_RXNE];
    status_o[4]  = fl[FL_NACK];
    status_o[5]  = fl[FL_STOP];
    status_o[6]  = fl[FL_TC];
    status_o[7]  = fl[FL_TCR];
    status_o[15] = fl[FL_BUSY];
  end

  assign irq_o = |(ie_i & {fl[FL_TC] | fl[FL_TCR], fl[FL_STOP], fl[FL_NACK],
                           fl[FL_RXNE], fl[FL_TXIS]});
  assign rx_data_o = rxd_q;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic [4:0]  ie_i,
  input logic        ctrl_wr_i,
  input logic        tx_wr_i,
  input logic        rx_rd_i,
  input logic [7:0]  rx_data_o,
  input logic [15:0] status_o,
  input logic        irq_o,
  input logic        cmd_valid_o,
  input logic [1:0]  cmd_o,
  input logic        cmd_bit_o,
  input logic        bit_done_i
);
  logic unused_ie;
  assign unused_ie = ^ie_i[3:0];

  // R11
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && cmd_valid_o && !bit_done_i |=> cmd_valid_o && $stable(cmd_o) && $stable(cmd_bit_o));

  // R1
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> status_o == 16'h0 && !cmd_valid_o && !irq_o);

  // R6
  tc_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && status_o[6] && !ctrl_wr_i |=> status_o[6] && !cmd_valid_o);

  // R5
  rx_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && status_o[2] && !rx_rd_i |=> status_o[2] && $stable(rx_data_o));

  // R3
  txis_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && status_o[1] && tx_wr_i |=> !status_o[1]);

  // R7
  tc_tcr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_o[6], status_o[7]}));

  // R10
  stopf_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> !status_o[15]);

  // R12
  irq_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] || status_o[7]) && ie_i[4] |-> irq_o);
endmodule

bind i2c_xfer_seq i2cseq_chk u_chk (.*);

// File: tb/sim_i2c_xfer_seq.sv
module sim_i2c_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  ie = '0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl = '0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        clr_wr = 1'b0;
  logic [31:0] clr = '0;
  logic [15:0] status;
  logic        irq;
  logic        cmd_valid;
  logic [1:0]  cmd;
  logic        cmd_bit;
  logic        bit_done = 1'b0;
  logic        bit_rx = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit rx_q[$];
  int log_q[$];
  int exp_q[$];
  int lat = 1;
  int rcnt = 0;

  always #5 clk = ~clk;

  i2c_xfer_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .ie_i(ie),
    .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .rx_rd_i(rx_rd), .rx_data_o(rx_data), .clr_wr_i(clr_wr), .clr_i(clr),
    .status_o(status), .irq_o(irq), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .cmd_bit_o(cmd_bit), .bit_done_i(bit_done), .bit_rx_i(bit_rx)
  );

  // timing generator and target model; log entries: 0 START, 2 STOP, 4+b write, 6 read
  always @(posedge clk) begin
    if (!rst_n) begin
      bit_done <= 1'b0; rcnt = 0;
    end else if (bit_done) begin
      bit_done <= 1'b0;
    end else if (cmd_valid) begin
      if (rcnt >= lat) begin
        bit_done <= 1'b1; rcnt = 0; lat = $urandom_range(0, 2);
        if (cmd == 2'd3) begin
          bit_rx <= (rx_q.size() > 0) ? rx_q.pop_front() : 1'b0;
          log_q.push_back(6);
        end else if (cmd == 2'd2) log_q.push_back(4 + int'(cmd_bit));
        else log_q.push_back(2 * int'(cmd));
      end else rcnt++;
    end else rcnt = 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] cw(input logic [6:0] a, input logic rd, input int n,
                                     input logic rl, input logic st, input logic sp);
    return {7'b0, rl, n[7:0], 1'b0, sp, st, 2'b0, rd, 2'b0, a, 1'b0};
  endfunction

  task automatic e_start; exp_q.push_back(0); endtask
  task automatic e_stop;  exp_q.push_back(2); endtask
  task automatic e_rd;    exp_q.push_back(6); endtask
  task automatic e_wbit(input logic b); exp_q.push_back(4 + int'(b)); endtask
  task automatic e_wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) e_wbit(b[i]);
  endtask

  task automatic cmp_log(input string req);
    int bad = -1;
    if (log_q.size() == exp_q.size())
      for (int i = 0; i < log_q.size(); i++) if (bad < 0 && log_q[i] != exp_q[i]) bad = i;
    if (log_q.size() != exp_q.size())
      chk(1'b0, {req, " command count"}, log_q.size(), exp_q.size());
    else
      chk(bad < 0, {req, " command stream"}, bad < 0 ? 0 : log_q[bad], bad < 0 ? 0 : exp_q[bad]);
    log_q.delete(); exp_q.delete();
  endtask

  task automatic pulse_ctrl(input logic [31:0] w);
    @(negedge clk); ctrl = w; ctrl_wr = 1'b1; @(negedge clk); ctrl_wr = 1'b0;
  endtask
  task automatic pulse_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
  endtask
  task automatic pulse_rd;
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask
  task automatic pulse_clr(input logic [31:0] w);
    @(negedge clk); clr = w; clr_wr = 1'b1; @(negedge clk); clr_wr = 1'b0;
  endtask
  task automatic wait_st(input int b, input string req);
    int t = 0;
    while (!status[b] && t < 3000) begin @(negedge clk); t++; end
    chk(status[b] == 1'b1, req, status, 32'h1 << b);
  endtask

  // generic message: nack_at -1 none, 0 address, k data byte k (writes)
  task automatic run_xfer(input logic [6:0] a, input logic rd, input int n, input int nack_at,
                          input bit hold);
    logic [7:0] d[$];
    for (int i = 0; i < n; i++) d.push_back(8'($urandom));
    e_start(); e_wbyte({a, rd}); e_rd(); rx_q.push_back(nack_at == 0);
    if (nack_at != 0) begin
      for (int i = 0; i < n; i++) begin
        if (!rd) begin
          e_wbyte(d[i]); e_rd(); rx_q.push_back(nack_at == i + 1);
          if (nack_at == i + 1) break;
        end else begin
          for (int b = 7; b >= 0; b--) begin e_rd(); rx_q.push_back(d[i][b]); end
          e_wbit(i == n - 1);
        end
      end
    end
    e_stop();
    pulse_ctrl(cw(a, rd, n, 1'b0, 1'b1, 1'b0));
    if (nack_at != 0) begin
      for (int i = 0; i < n; i++) begin
        if (nack_at > 0 && i >= nack_at) break;
        if (!rd) begin
          wait_st(1, "R3 txis raised");
          pulse_tx(d[i]);
        end else begin
          wait_st(2, "R4 rxne raised");
          chk(rx_data == d[i], "R4 received byte", rx_data, d[i]);
          if (hold && i == 0) begin
            repeat (60) @(negedge clk);
            chk(log_q.size() == 27 && !cmd_valid, "R5 stall while rxne set", log_q.size(), 27);
            chk(status[2] && rx_data == d[0], "R5 byte held", rx_data, d[0]);
          end
          pulse_rd();
        end
      end
    end
    if (nack_at >= 0) begin
      wait_st(5, "R9 stop after nack");
      chk(status[4] && !status[6], "R9 nackf without tc", status, 16'h0030);
    end else begin
      wait_st(6, n == 0 ? "R8 zero count to tc" : "R6 tc at end");
      chk(!cmd_valid, "R6 bus parked", cmd_valid, 0);
      pulse_ctrl(cw(7'h0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
      wait_st(5, "R10 stopf");
    end
    @(negedge clk);
    chk(!status[15], "R2 busy low after stop", status[15], 0);
    cmp_log(rd ? "R4 read message" : "R3 write message");
    pulse_clr(32'h30);
    chk(status == 16'h0, "R10 flags cleared", status, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    ie = 5'h1f;
    repeat (3) @(negedge clk);
    chk(status == 16'h0 && !cmd_valid && !irq, "R1 reset state", status, 0);
    rst_n = 1'b1;
    @(negedge clk); enable = 1'b1; ie = '0;
    @(negedge clk);

    // directed basic messages
    run_xfer(7'h5a, 1'b0, 3, -1, 1'b0);
    run_xfer(7'h21, 1'b1, 3, -1, 1'b0);
    run_xfer(7'h33, 1'b1, 2, -1, 1'b1);
    run_xfer(7'h10, 1'b0, 0, -1, 1'b0);
    run_xfer(7'h11, 1'b1, 0, -1, 1'b0);

    // R9 address nack and R10 zero clear
    begin
      e_start(); e_wbyte({7'h7f, 1'b0}); e_rd(); e_stop(); rx_q.push_back(1'b1);
      pulse_ctrl(cw(7'h7f, 1'b0, 4, 1'b0, 1'b1, 1'b0));
      wait_st(5, "R9 address nack stop");
      chk(status[4] && !status[1], "R9 nackf, no byte asked", status, 16'h0030);
      cmp_log("R9 address nack");
      pulse_clr(32'h0);
      chk(status[4] && status[5], "R10 zero clear no effect", status, 16'h0030);
      pulse_clr(32'h10);
      chk(!status[4] && status[5], "R10 nack clear only", status, 16'h0020);
      pulse_clr(32'h20);
      chk(status == 16'h0, "R10 stop clear", status, 0);
    end
    run_xfer(7'h44, 1'b0, 4, 2, 1'b0);

    // R7 write with reload chunk
    begin
      logic [7:0] d0 = 8'hc3, d1 = 8'h18, d2 = 8'hf0;
      e_start(); e_wbyte({7'h2b, 1'b0}); e_rd();
      e_wbyte(d0); e_rd(); e_wbyte(d1); e_rd(); e_wbyte(d2); e_rd(); e_stop();
      for (int i = 0; i < 4; i++) rx_q.push_back(1'b0);
      pulse_ctrl(cw(7'h2b, 1'b0, 2, 1'b1, 1'b1, 1'b0));
      wait_st(1, "R3 txis"); pulse_tx(d0);
      wait_st(1, "R3 txis"); pulse_tx(d1);
      wait_st(7, "R7 tcr raised");
      repeat (20) @(negedge clk);
      chk(!status[6] && status[7] && !cmd_valid && log_q.size() == 28, "R7 parked in tcr",
          log_q.size(), 28);
      ie = 5'h10;
      #1 chk(irq, "R12 irq on tcr", irq, 1);
      ie = '0;
      pulse_ctrl(cw(7'h0, 1'b0, 1, 1'b0, 1'b0, 1'b0));
      wait_st(1, "R7 resume without start"); pulse_tx(d2);
      wait_st(6, "R7 tc after final chunk");
      pulse_ctrl(cw(7'h0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
      wait_st(5, "R10 stopf");
      cmp_log("R7 reload write");
      pulse_clr(32'h30);
    end

    // R4 read with reload chunk: ack 0 inside reload chunk, 1 at the end
    begin
      logic [7:0] d0 = 8'h96, d1 = 8'h3c;
      e_start(); e_wbyte({7'h52, 1'b1}); e_rd(); rx_q.push_back(1'b0);
      for (int b = 7; b >= 0; b--) begin e_rd(); rx_q.push_back(d0[b]); end
      e_wbit(1'b0);
      for (int b = 7; b >= 0; b--) begin e_rd(); rx_q.push_back(d1[b]); end
      e_wbit(1'b1); e_stop();
      pulse_ctrl(cw(7'h52, 1'b1, 1, 1'b1, 1'b1, 1'b0));
      wait_st(2, "R4 rxne"); chk(rx_data == d0, "R4 reload byte", rx_data, d0); pulse_rd();
      wait_st(7, "R7 tcr on read");
      pulse_ctrl(cw(7'h0, 1'b1, 1, 1'b0, 1'b0, 1'b0));
      wait_st(2, "R4 rxne"); chk(rx_data == d1, "R4 last byte", rx_data, d1); pulse_rd();
      wait_st(6, "R6 tc");
      pulse_ctrl(cw(7'h0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
      wait_st(5, "R10 stopf");
      cmp_log("R4 reload read");
      pulse_clr(32'h30);
    end

    // R6 repeated start, then start+stop together: stop wins
    begin
      logic [7:0] d0 = 8'h5e, d1 = 8'ha1;
      e_start(); e_wbyte({7'h19, 1'b0}); e_rd(); e_wbyte(d0); e_rd();
      e_start(); e_wbyte({7'h19, 1'b1}); e_rd();
      for (int b = 7; b >= 0; b--) e_rd();
      e_wbit(1'b1); e_stop();
      rx_q.push_back(1'b0); rx_q.push_back(1'b0); rx_q.push_back(1'b0);
      for (int b = 7; b >= 0; b--) rx_q.push_back(d1[b]);
      pulse_ctrl(cw(7'h19, 1'b0, 1, 1'b0, 1'b1, 1'b0));
      wait_st(1, "R3 txis"); pulse_tx(d0);
      wait_st(6, "R6 tc before restart");
      pulse_ctrl(cw(7'h19, 1'b1, 1, 1'b0, 1'b1, 1'b0));
      wait_st(2, "R6 restart read byte");
      chk(rx_data == d1 && status[15], "R6 restart data, bus busy", rx_data, d1);
      pulse_rd();
      wait_st(6, "R6 tc after restart");
      pulse_ctrl(cw(7'h0, 1'b0, 2, 1'b0, 1'b1, 1'b1));
      wait_st(5, "R6 stop wins");
      repeat (30) @(negedge clk);
      chk(!cmd_valid && !status[15], "R6 no new start", status, 16'h0020);
      cmp_log("R6 repeated start");
      pulse_clr(32'h30);
    end

    // R12 irq gating and R13 disable mid-message
    begin
      rx_q.push_back(1'b0);
      pulse_ctrl(cw(7'h0c, 1'b0, 2, 1'b0, 1'b1, 1'b0));
      wait_st(1, "R3 txis");
      chk(!irq, "R12 irq masked", irq, 0);
      ie = 5'h01; #1 chk(irq, "R12 tx irq", irq, 1);
      ie = 5'h1e; #1 chk(!irq, "R12 other enables", irq, 0);
      ie = '0;
      @(negedge clk); enable = 1'b0;
      @(negedge clk);
      chk(status == 16'h0 && !cmd_valid, "R13 abort clears", status, 0);
      enable = 1'b1;
      repeat (10) @(negedge clk);
      chk(!cmd_valid && status == 16'h0, "R13 stays idle", status, 0);
      log_q.delete(); exp_q.delete(); rx_q.delete();
    end

    // constrained random messages
    for (int k = 0; k < 10; k++) begin
      logic rd = 1'($urandom_range(0, 1));
      int n = $urandom_range(0, 4);
      int na = -1;
      if ($urandom_range(0, 3) == 0) na = rd ? 0 : $urandom_range(0, n);
      run_xfer(7'($urandom), rd, n, na, 1'b0);
    end

    repeat (5) @(negedge clk);
    finish_up();
  end
endmodule